// File: doc/BRIEF.md
# Multiplexed External Data Memory Bus Controller

This block converts single read or write requests from inside the chip into bus cycles on an 8-bit shared address/data port. A latch strobe lets an external register capture the low address byte, after which the same port carries the data byte. A separate high port supplies the upper address byte in linear mode. In paged mode the high port is left alone so software can use it as a page register. Active-low read and write strobes frame the data phase. A 2-bit setting stretches them by zero to three extra clock cycles.

A request is accepted only while the controller is idle. While a cycle is in progress, `busy` holds off any new request. A one-cycle `done` pulse marks the end of every cycle. Between cycles the latch strobe either toggles freely at a fixed rate or is parked high. The shared port either floats or drives a configured idle value.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: During reset and until the first request, `rd_n` and `wr_n` are 1, `busy` and `done` are 0, and `lo_oe` is 0 while `rst_n` is low.
- R2: An accepted request (`req_valid` high at a clock edge while `busy` is 0) starts an address phase in the next cycle. In that cycle `ale` is 1 and `lo_out` carries `req_addr[7:0]` with `lo_oe` 1. In the following cycle `ale` is 0 and the same address is still driven, so the address is steady across the falling edge of `ale`.
- R3: In linear mode (`req_paged` = 0), `hi_drive` is 1 and `hi_out` equals `req_addr[15:8]` from the address phase until `done`.
- R4: In paged mode (`req_paged` = 1), `hi_drive` stays 0 and `hi_out` keeps the value it had before the request.
- R5: The strobe of the access (`wr_n` for `req_write` = 1, `rd_n` for 0) is low for exactly 1 + `cfg_wait` cycles, starting in the third cycle after acceptance. The two strobes are never low together.
- R6: On a write, `lo_out` = `req_wdata` with `lo_oe` 1 for every cycle `wr_n` is low and for the one cycle after it rises.
- R7: On a read, `lo_oe` is 0 from the first strobe cycle through the `done` cycle. `rdata` takes `lo_in` as sampled at the clock edge that ends the last `rd_n`-low cycle, and is valid while `done` is 1.
- R8: `done` is 1 for exactly one cycle, the cycle right after the strobe rises. `busy` is 1 for 4 + `cfg_wait` cycles per access and 0 in the cycle after `done`.
- R9: A request presented while `busy` is 1 does not disturb the running cycle. If it is still held when the controller returns to idle, it is accepted at the first idle edge.
- R10: While idle with `cfg_ale_park` = 1, `ale` is held at 1.
- R11: While idle with `cfg_ale_park` = 0, `ale` toggles every `ALE_HALF` cycles (default 2).
- R12: While idle (after reset), `lo_oe` equals `cfg_lo_idle_oe` and `lo_out` equals `cfg_lo_idle_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, taken while not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_paged | input | 1 | 1 = 8-bit paged, 0 = 16-bit linear |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Cycle in progress; new requests held off |
| done | output | 1 | One-cycle end-of-access pulse |
| rdata | output | 8 | Captured read data |
| cfg_wait | input | 2 | Extra strobe cycles (0..3) |
| cfg_ale_park | input | 1 | 1 = latch strobe held high while idle |
| cfg_lo_idle_oe | input | 1 | Shared port drive enable while idle |
| cfg_lo_idle_val | input | 8 | Shared port value while idle |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| lo_out | output | 8 | Shared address/data port, output value |
| lo_oe | output | 1 | Shared port push-pull enable |
| lo_in | input | 8 | Shared port, input value |
| hi_out | output | 8 | High address port value |
| hi_drive | output | 1 | High port owned by the controller |

## Verification
The assertions assume that `rst_n` is held low over at least one clock edge before it is released. They also assume that request fields and `cfg_wait` are steady at the edge where a request is accepted, and that `lo_in` is steady around the sampling edge. The bench drives every input at the falling clock edge, so all of them are settled at the next rising edge. During read strobes it drives `lo_in` with a decoy value except in the cycle before the sampling edge. It toggles `cfg_ale_park` and the idle-port settings only while the controller is idle.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
   typedef enum logic [2:0] {
      XS_IDLE  = 3'd0,
      XS_ADDR  = 3'd1,
      XS_LATCH = 3'd2,
      XS_STRB  = 3'd3,
      XS_HOLD  = 3'd4
   } xm_state_t;
endpackage

// File: rtl/xmem_seq.sv
module xmem_seq
   import xmem_pkg::*;
#(
   parameter int DW  = 8,
   parameter int AW  = 16,
   parameter int WSW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic          req_paged,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic [WSW-1:0] cfg_wait,
   input  logic [DW-1:0] lo_in,
   output xm_state_t     st,
   output logic          cur_write,
   output logic          cur_paged,
   output logic [DW-1:0] cur_lo,
   output logic [DW-1:0] cur_wdata,
   output logic [AW-DW-1:0] hi_q,
   output logic [DW-1:0] rdata,
   output logic          armed,
   output logic          busy,
   output logic          done
);
   localparam int HW = AW - DW;

   logic [WSW-1:0] wcnt, wlim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= XS_IDLE;
         wcnt      <= '0;
         wlim      <= '0;
         cur_write <= 1'b0;
         cur_paged <= 1'b0;
         cur_lo    <= '0;
         cur_wdata <= '0;
         hi_q      <= '0;
         rdata     <= '0;
         armed     <= 1'b0;
      end else begin
         armed <= 1'b1;
         case (st)
            XS_IDLE: if (req_valid) begin
               st        <= XS_ADDR;
               cur_write <= req_write;
               cur_paged <= req_paged;
               cur_lo    <= req_addr[DW-1:0];
               cur_wdata <= req_wdata;
               wlim      <= cfg_wait;
               if (!req_paged) hi_q <= req_addr[AW-1:DW];
            end
            XS_ADDR:  st <= XS_LATCH;
            XS_LATCH: begin
               st   <= XS_STRB;
               wcnt <= '0;
            end
            XS_STRB: begin
               if (wcnt == wlim) begin
                  st <= XS_HOLD;
                  if (!cur_write) rdata <= lo_in;
               end else begin
                  wcnt <= wcnt + 1'b1;
               end
            end
            XS_HOLD:  st <= XS_IDLE;
            default:  st <= XS_IDLE;
         endcase
      end
   end

   assign busy = (st != XS_IDLE);
   assign done = (st == XS_HOLD);

   // R5: the wait counter never runs past the limit latched at acceptance
   p_wait_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == XS_STRB) |-> (wcnt <= wlim));
   // R8: done lasts one cycle and returns the controller to idle
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));
   // R9: the captured request stays frozen while a cycle runs
   p_holdoff_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> ($stable(cur_lo) && $stable(cur_write) && $stable(cur_wdata)));

   if (HW < 1) begin : g_bad_aw
      $error("xmem_seq: AW must exceed DW");
   end
endmodule

// File: rtl/xmem_ale_gen.sv
module xmem_ale_gen #(
   parameter int ALE_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic idle,
   input  logic park,
   input  logic bus_ale,
   output logic ale
);
   logic tog;

   if (ALE_HALF < 1) begin : g_bad_half
      $error("xmem_ale_gen: ALE_HALF must be at least 1");
   end else if (ALE_HALF == 1) begin : g_fast
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tog <= 1'b1;
         else        tog <= ~tog;
      end
   end else begin : g_div
      localparam int CW = $clog2(ALE_HALF);
      localparam logic [CW-1:0] CMAX = CW'(ALE_HALF - 1);
      logic [CW-1:0] dcnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dcnt <= '0;
            tog  <= 1'b1;
         end else if (dcnt == CMAX) begin
            dcnt <= '0;
            tog  <= ~tog;
         end else begin
            dcnt <= dcnt + 1'b1;
         end
      end
   end

   assign ale = idle ? (park | tog) : bus_ale;
endmodule

// File: rtl/xmem_pin_mux.sv
module xmem_pin_mux
   import xmem_pkg::*;
#(
   parameter int DW = 8
) (
   input  xm_state_t     st,
   input  logic          cur_write,
   input  logic          cur_paged,
   input  logic [DW-1:0] cur_lo,
   input  logic [DW-1:0] cur_wdata,
   input  logic          armed,
   input  logic          idle_oe,
   input  logic [DW-1:0] idle_val,
   output logic [DW-1:0] lo_out,
   output logic          lo_oe,
   output logic          rd_n,
   output logic          wr_n,
   output logic          hi_drive,
   output logic          bus_ale
);
   always_comb begin
      lo_out   = '0;
      lo_oe    = 1'b0;
      rd_n     = 1'b1;
      wr_n     = 1'b1;
      bus_ale  = 1'b0;
      hi_drive = (st != XS_IDLE) && !cur_paged;
      case (st)
         XS_IDLE: begin
            lo_oe  = idle_oe & armed;
            lo_out = idle_val;
         end
         XS_ADDR: begin
            bus_ale = 1'b1;
            lo_oe   = 1'b1;
            lo_out  = cur_lo;
         end
         XS_LATCH: begin
            lo_oe  = 1'b1;
            lo_out = cur_lo;
         end
         XS_STRB: begin
            rd_n   = cur_write;
            wr_n   = !cur_write;
            lo_oe  = cur_write;
            lo_out = cur_write ? cur_wdata : '0;
         end
         XS_HOLD: begin
            lo_oe  = cur_write;
            lo_out = cur_write ? cur_wdata : '0;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
   import xmem_pkg::*;
#(
   parameter int DW       = 8,
   parameter int AW       = 16,
   parameter int WSW      = 2,
   parameter int ALE_HALF = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic          req_paged,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] rdata,
   input  logic [WSW-1:0] cfg_wait,
   input  logic          cfg_ale_park,
   input  logic          cfg_lo_idle_oe,
   input  logic [DW-1:0] cfg_lo_idle_val,
   output logic          ale,
   output logic          rd_n,
   output logic          wr_n,
   output logic [DW-1:0] lo_out,
   output logic          lo_oe,
   input  logic [DW-1:0] lo_in,
   output logic [AW-DW-1:0] hi_out,
   output logic          hi_drive
);
   xm_state_t     st;
   logic          cur_write, cur_paged, armed, bus_ale;
   logic [DW-1:0] cur_lo, cur_wdata;

   if (WSW < 1) begin : g_bad_wsw
      $error("xmem_bus_ctrl: WSW must be at least 1");
   end

   xmem_seq #(.DW(DW), .AW(AW), .WSW(WSW)) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_paged(req_paged), .req_addr(req_addr), .req_wdata(req_wdata),
      .cfg_wait(cfg_wait), .lo_in(lo_in), .st(st), .cur_write(cur_write),
      .cur_paged(cur_paged), .cur_lo(cur_lo), .cur_wdata(cur_wdata),
      .hi_q(hi_out), .rdata(rdata), .armed(armed), .busy(busy), .done(done)
   );

   xmem_pin_mux #(.DW(DW)) u_pins (
      .st(st), .cur_write(cur_write), .cur_paged(cur_paged), .cur_lo(cur_lo),
      .cur_wdata(cur_wdata), .armed(armed), .idle_oe(cfg_lo_idle_oe),
      .idle_val(cfg_lo_idle_val), .lo_out(lo_out), .lo_oe(lo_oe),
      .rd_n(rd_n), .wr_n(wr_n), .hi_drive(hi_drive), .bus_ale(bus_ale)
   );

   xmem_ale_gen #(.ALE_HALF(ALE_HALF)) u_ale (
      .clk(clk), .rst_n(rst_n), .idle(!busy), .park(cfg_ale_park),
      .bus_ale(bus_ale), .ale(ale)
   );

   // R5: read and write strobes are mutually exclusive
   p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_n || wr_n));
   // R7: shared port floats while the read strobe is low
   p_rd_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !lo_oe);
   // R6: write data still driven in the cycle after the write strobe rises
   p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_n) |-> (lo_oe && $stable(lo_out)));
   // R2: address held steady across the falling latch strobe of a bus cycle
   p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $fell(ale)) |-> (lo_oe && $stable(lo_out) && $stable(hi_out)));
   // R4: high port untouched whenever the controller does not own it
   p_paged_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !hi_drive) |-> $stable(hi_out));
endmodule

// File: tb/sim_xmem_bus_ctrl.sv
`timescale 1ns/1ps
module sim_xmem_bus_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_paged = 1'b0;
   logic [15:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        busy, done;
   logic [7:0]  rdata;
   logic [1:0]  cfg_wait = '0;
   logic        cfg_ale_park = 1'b1, cfg_lo_idle_oe = 1'b1;
   logic [7:0]  cfg_lo_idle_val = 8'h5A;
   logic        ale, rd_n, wr_n, lo_oe, hi_drive;
   logic [7:0]  lo_out, hi_out;
   logic [7:0]  lo_in = 8'hEE;

   int n_vec = 0, n_bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   xmem_bus_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_paged(req_paged), .req_addr(req_addr), .req_wdata(req_wdata),
      .busy(busy), .done(done), .rdata(rdata), .cfg_wait(cfg_wait),
      .cfg_ale_park(cfg_ale_park), .cfg_lo_idle_oe(cfg_lo_idle_oe),
      .cfg_lo_idle_val(cfg_lo_idle_val), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
      .lo_out(lo_out), .lo_oe(lo_oe), .lo_in(lo_in), .hi_out(hi_out),
      .hi_drive(hi_drive)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(rd_n == 1'b1 && wr_n == 1'b1, "R1 strobes", {rd_n, wr_n}, 3);
      chk(lo_oe == 1'b0, "R1 lo_oe", lo_oe, 0);
      chk(busy == 1'b0 && done == 1'b0, "R1 busy/done", {busy, done}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(rd_n == 1'b1 && wr_n == 1'b1 && !busy, "R1 after release", {rd_n, wr_n, busy}, 6);
   endtask

   task automatic access(input bit w, input bit p, input logic [15:0] a,
                         input logic [7:0] d, input logic [1:0] ws);
      logic [7:0] hprev;
      int last;
      @(negedge clk);
      cfg_wait = ws; req_valid = 1'b1; req_write = w; req_paged = p;
      req_addr = a; req_wdata = d; hprev = hi_out; lo_in = ~d;
      @(negedge clk);
      req_valid = 1'b0;
      last = 4 + int'(ws);
      for (int k = 0; k <= last; k++) begin
         bit strb;
         strb = (k >= 2) && (k <= 2 + int'(ws));
         if (k <= 1) begin
            chk(ale == (k == 0), "R2 ale phase", ale, (k == 0));
            chk(lo_oe && lo_out == a[7:0], "R2 address on low port", lo_out, a[7:0]);
         end else if (k < last) begin
            chk(ale == 1'b0, "R2 ale low in data phase", ale, 0);
         end
         if (k < last) begin
            chk(busy == 1'b1, "R8 busy", busy, 1);
            if (!p) chk(hi_drive && hi_out == a[15:8], "R3 high byte", hi_out, a[15:8]);
            else    chk(!hi_drive && hi_out == hprev, "R4 high port untouched", hi_out, hprev);
            chk(rd_n == !(strb && !w), "R5 rd_n", rd_n, !(strb && !w));
            chk(wr_n == !(strb && w), "R5 wr_n", wr_n, !(strb && w));
            chk(done == (k == last - 1), "R8 done", done, (k == last - 1));
         end else begin
            chk(busy == 1'b0 && done == 1'b0, "R8 idle after done", {busy, done}, 0);
         end
         if (k >= 2 && k <= last - 1) begin
            if (w) chk(lo_oe && lo_out == d, "R6 write data", lo_out, d);
            else   chk(!lo_oe, "R7 port floats", lo_oe, 0);
         end
         if (!w && k == last - 1) chk(rdata == d, "R7 read capture", rdata, d);
         lo_in = (!w && k == 2 + int'(ws)) ? d : ~d;
         if (k < last) @(negedge clk);
      end
   endtask

   task automatic t_holdoff();
      @(negedge clk);
      cfg_wait = 2'd1; req_valid = 1'b1; req_write = 1'b0; req_paged = 1'b0;
      req_addr = 16'h3344;
      @(negedge clk);
      req_write = 1'b1; req_addr = 16'h5566; req_wdata = 8'h77;
      for (int k = 0; k <= 5; k++) begin
         if (k <= 4) chk(busy == 1'b1, "R9 busy during cycle", busy, 1);
         if (k == 1) chk(lo_out == 8'h44, "R9 address not disturbed", lo_out, 8'h44);
         if (k == 2) chk(rd_n == 1'b0 && wr_n == 1'b1, "R9 still a read", {rd_n, wr_n}, 1);
         if (k == 3) chk(hi_out == 8'h33, "R9 high byte kept", hi_out, 8'h33);
         if (k == 5) chk(busy == 1'b0, "R9 idle before next", busy, 0);
         @(negedge clk);
      end
      chk(busy && ale && lo_out == 8'h66, "R9 held request accepted", lo_out, 8'h66);
      chk(hi_out == 8'h55, "R9 held request high byte", hi_out, 8'h55);
      req_valid = 1'b0;
      while (busy) @(negedge clk);
   endtask

   task automatic t_idle_port();
      cfg_lo_idle_oe = 1'b1; cfg_lo_idle_val = 8'hA5;
      @(negedge clk);
      chk(lo_oe && lo_out == 8'hA5, "R12 idle drive", lo_out, 8'hA5);
      cfg_lo_idle_oe = 1'b0;
      @(negedge clk);
      chk(!lo_oe, "R12 idle float", lo_oe, 0);
   endtask

   task automatic t_ale_idle();
      int tr;
      logic prev;
      cfg_ale_park = 1'b1;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         chk(ale == 1'b1, "R10 parked ale", ale, 1);
      end
      cfg_ale_park = 1'b0;
      @(negedge clk);
      prev = ale; tr = 0;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         if (ale != prev) tr++;
         prev = ale;
      end
      chk(tr == 8, "R11 free-running ale transitions", tr, 8);
      cfg_ale_park = 1'b1;
   endtask

   initial begin
      t_reset();
      t_idle_port();
      t_ale_idle();
      access(1'b1, 1'b0, 16'h1234, 8'hC3, 2'd0);
      access(1'b0, 1'b0, 16'hABCD, 8'h69, 2'd3);
      access(1'b1, 1'b1, 16'h9F80, 8'h0F, 2'd2);
      access(1'b0, 1'b1, 16'h7701, 8'h96, 2'd1);
      access(1'b1, 1'b0, 16'hFFFF, 8'h00, 2'd1);
      access(1'b0, 1'b0, 16'h0000, 8'hFF, 2'd0);
      t_holdoff();
      cfg_ale_park = 1'b0;
      access(1'b1, 1'b0, 16'h2468, 8'h5C, 2'd3);
      t_idle_port();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule